// File: doc/BRIEF.md
# Parallel Port Interrupt Controller

This block gathers the interrupt sources of a printer-style parallel interface and turns them into a single prioritised interrupt line. It watches five asynchronous lines from the peripheral: acknowledge (active low), error (active low), select, paper-empty and busy. It also watches the full and empty flags of the data FIFO. Software reaches three registers through a small register port. An interrupt register is an enable field when written and a request field when read. A control/status register holds the master enable, the read-only summary request, the level code, the transfer mode bits and two DMA enables. A level register sets the 2-bit level code.

Some sources are level conditions that track the live signal. The others are sticky edge events that software clears by writing 0. Acknowledge reacts only to a falling edge. Error, select and paper-empty react to both edges. The peripheral lines pass through a two-flop synchronizer before edge detection. The interrupt output is one-hot across four wires, one for each of the levels 3 to 6.

Top module: `ppi_irq_ctrl`

## Requirements
- R1: Register address 1 is the interrupt register. Bit 5 always reads 0, and the register reads 0x00 after reset. Address 3 reads 0x00 and ignores writes.
- R2: Interrupt bits 7 (FIFO full), 6 (FIFO empty) and 4 (busy low) are level sources. When a 1 has been written to a bit, it reads the live condition. When a 0 has been written, it reads 0.
- R3: Interrupt bit 3, when enabled, is set by a falling edge of the acknowledge line only. A rising edge leaves it unchanged.
- R4: Interrupt bits 2 (error), 1 (select) and 0 (paper-empty), when enabled, are each set by either edge of their line.
- R5: A set edge bit stays set while 1 is written to it. Writing 0 clears it and disables it. A disabled edge bit is never set.
- R6: If an edge event on an enabled bit occurs in the same cycle as a write of 0 to that bit, the bit ends up set.
- R7: Control/status register (address 0) read layout: bit 7 IE, bit 6 IR, bits 5:4 level code, bit 3 I/O mode, bit 2 direction, bits 1:0 DMA enables. Writes load bits 7 and 3:0; written bits 6:4 are ignored. The level code is written at address 2, bits 5:4.
- R8: IR reads 1 whenever any interrupt register bit reads 1, whatever the value of IE.
- R9: The output `irq_lvl_o` is registered one cycle after IE and IR. It is one-hot: level code 0/1/2/3 drives bit 0/1/2/3, which stands for level 3/4/5/6. It is all zero unless IE and IR are both 1.
- R10: A soft reset pulse clears the whole interrupt register, the output and every control/status bit except the level code. The hard reset `rst_n` also clears the level code.
- R11: A change on a peripheral line shows in the interrupt register three rising edges later for edge sources, and two rising edges later for the busy level source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset pulse |
| reg_addr_i | input | 2 | Register address (0 ctrl, 1 interrupt, 2 level) |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| line_nack_i | input | 1 | Acknowledge line, active low, asynchronous |
| line_nerror_i | input | 1 | Error line, active low, asynchronous |
| line_select_i | input | 1 | Select line, asynchronous |
| line_pe_i | input | 1 | Paper-empty line, asynchronous |
| line_busy_i | input | 1 | Busy line, active high, asynchronous |
| fifo_full_i | input | 1 | FIFO full flag, synchronous |
| fifo_empty_i | input | 1 | FIFO empty flag, synchronous |
| irq_lvl_o | output | 4 | One-hot interrupt, bit n = level n+3 |
| mode_iom_o | output | 1 | I/O mode bit |
| mode_dir_o | output | 1 | Direction bit |
| dma_en_o | output | 2 | DMA channel enables |

## Verification
The FIFO flags reach the read data in the same cycle, so the bench samples them one time step after driving. The busy line needs two rising edges and the edge sources need three, so the bench reads once just before the third edge and once just after it. Register writes take effect on the rising edge inside the write task. `irq_lvl_o` follows one edge later, so the output checks wait one more rising edge. The same-cycle clear test puts the write strobe on exactly the edge where the synchronized edge event is present.

// File: rtl/ppi_irq_pkg.sv
// Shared constants and types for the parallel port interrupt controller.
// Assumes an 8-bit register port with four addresses.
package ppi_irq_pkg;
    localparam int DW        = 8;
    localparam int AW        = 2;
    localparam int NSTICKY   = 4;   // PE, SELECT, ERROR, ACK at bits 0..3
    localparam int NLEVEL    = 3;   // nBUSY, EMPTY, FULL
    localparam int NLVL_OUT  = 4;   // interrupt output wires
    localparam int LVLW      = $clog2(NLVL_OUT);
    localparam int SYNC_STG  = 2;
    localparam int NLINES    = NSTICKY + 1;

    typedef enum logic [1:0] {EDGE_FALL, EDGE_RISE, EDGE_BOTH} edge_sel_e;
    typedef enum logic [AW-1:0] {A_CTRL = 2'd0, A_IRQ = 2'd1, A_LVL = 2'd2, A_NONE = 2'd3} reg_addr_e;

    // edge polarity per sticky bit; index 3 (acknowledge) is falling only
    localparam edge_sel_e STICKY_EDGE [NSTICKY] = '{EDGE_BOTH, EDGE_BOTH, EDGE_BOTH, EDGE_FALL};
endpackage

// File: rtl/ppi_line_sync.sv
// Multi-stage synchronizer for asynchronous peripheral lines. It also keeps
// one extra delayed copy so that edges can be found downstream.
// Assumes each line is independent; all flops reset to 0.
module ppi_line_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    // shift the lines through the synchronizer chain and keep the last sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign cur_o  = stg[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/ppi_irq_bank.sv
// Interrupt enable/request bank. Level sources read their live condition
// while enabled. Edge sources latch an event until a 0 is written.
// Assumes line samples are already synchronized; soft clear beats all else,
// and a new event beats a clear-write in the same cycle.
module ppi_irq_bank
    import ppi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr_i,
    input  logic               wr_i,
    input  logic [NSTICKY-1:0] wen_st_i,
    input  logic [NLEVEL-1:0]  wen_lv_i,
    input  logic [NSTICKY-1:0] line_cur_i,
    input  logic [NSTICKY-1:0] line_prev_i,
    input  logic [NLEVEL-1:0]  lv_cond_i,
    output logic [NLEVEL-1:0]  lv_flag_o,
    output logic [NSTICKY-1:0] st_en_o,
    output logic [NSTICKY-1:0] st_pend_o,
    output logic [NSTICKY-1:0] st_evt_o
);
    logic [NSTICKY-1:0] st_en_q, st_pend_q, evt;
    logic [NLEVEL-1:0]  lv_en_q;

    for (genvar g = 0; g < NSTICKY; g++) begin : g_st
        // pick the edge detector this bit is built with
        if (STICKY_EDGE[g] == EDGE_FALL) begin : g_fall
            assign evt[g] = line_prev_i[g] & ~line_cur_i[g];
        end else if (STICKY_EDGE[g] == EDGE_RISE) begin : g_rise
            assign evt[g] = ~line_prev_i[g] & line_cur_i[g];
        end else begin : g_both
            assign evt[g] = line_prev_i[g] ^ line_cur_i[g];
        end

        // enable bit follows each write
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr_i) st_en_q[g] <= 1'b0;
            else if (wr_i)            st_en_q[g] <= wen_st_i[g];
        end

        // request bit: set by enabled event, cleared by written zero
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr_i)         st_pend_q[g] <= 1'b0;
            else if (st_en_q[g] && evt[g])    st_pend_q[g] <= 1'b1;
            else if (wr_i && !wen_st_i[g])    st_pend_q[g] <= 1'b0;
        end
    end

    // level enables follow each write
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) lv_en_q <= '0;
        else if (wr_i)            lv_en_q <= wen_lv_i;
    end

    assign lv_flag_o = lv_en_q & lv_cond_i;
    assign st_en_o   = st_en_q;
    assign st_pend_o = st_pend_q;
    assign st_evt_o  = evt;
endmodule

// File: rtl/ppi_irq_csr.sv
// Control/status and level-code storage, plus the registered one-hot
// interrupt output. The level code survives a soft reset but not a hard one.
// Assumes pending_i is the summary request from the interrupt bank.
module ppi_irq_csr
    import ppi_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_clr_i,
    input  logic                ctl_wr_i,
    input  logic                lvl_wr_i,
    input  logic                ie_wd_i,
    input  logic [3:0]          mode_wd_i,
    input  logic [LVLW-1:0]     lvl_wd_i,
    input  logic                pending_i,
    output logic                ie_o,
    output logic [LVLW-1:0]     il_o,
    output logic [3:0]          mode_o,
    output logic [NLVL_OUT-1:0] irq_o
);
    logic                ie_q;
    logic [3:0]          mode_q;
    logic [LVLW-1:0]     il_q;
    logic [NLVL_OUT-1:0] irq_q;

    // master enable and mode bits, cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            ie_q   <= 1'b0;
            mode_q <= '0;
        end else if (ctl_wr_i) begin
            ie_q   <= ie_wd_i;
            mode_q <= mode_wd_i;
        end
    end

    // level code, cleared by hard reset only
    always_ff @(posedge clk) begin
        if (!rst_n)        il_q <= '0;
        else if (lvl_wr_i) il_q <= lvl_wd_i;
    end

    for (genvar k = 0; k < NLVL_OUT; k++) begin : g_out
        // drive output wire k when the level code selects it
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr_i) irq_q[k] <= 1'b0;
            else irq_q[k] <= ie_q && pending_i && (il_q == LVLW'(k));
        end
    end

    assign ie_o   = ie_q;
    assign il_o   = il_q;
    assign mode_o = mode_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/ppi_irq_ctrl.sv
// Top of the parallel port interrupt controller: synchronizes the
// peripheral lines, decodes register accesses and forms read data.
// Assumes the FIFO flags are already in the clk domain.
module ppi_irq_ctrl
    import ppi_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    input  logic                line_nack_i,
    input  logic                line_nerror_i,
    input  logic                line_select_i,
    input  logic                line_pe_i,
    input  logic                line_busy_i,
    input  logic                fifo_full_i,
    input  logic                fifo_empty_i,
    output logic [NLVL_OUT-1:0] irq_lvl_o,
    output logic                mode_iom_o,
    output logic                mode_dir_o,
    output logic [1:0]          dma_en_o
);
    logic [NLINES-1:0]  ln_cur, ln_prev;
    logic [NLEVEL-1:0]  lv_cond, lv_flag;
    logic [NSTICKY-1:0] sticky_en_w, sticky_pend_w, sticky_evt_w;
    logic               ie_w, ir_w;
    logic [LVLW-1:0]    il_w;
    logic [3:0]         mode_w;
    logic [DW-1:0]      irq_rd, ctl_rd, lvl_rd;
    logic               wr_ctl, wr_irq, wr_lvl;

    ppi_line_sync #(.W(NLINES), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({line_busy_i, line_nack_i, line_nerror_i, line_select_i, line_pe_i}),
        .cur_o   (ln_cur),
        .prev_o  (ln_prev)
    );

    // address decode of the write strobe
    always_comb begin
        wr_ctl = reg_wr_i && (reg_addr_i == A_CTRL);
        wr_irq = reg_wr_i && (reg_addr_i == A_IRQ);
        wr_lvl = reg_wr_i && (reg_addr_i == A_LVL);
    end

    // level conditions ordered nBUSY, EMPTY, FULL
    assign lv_cond = {fifo_full_i, fifo_empty_i, ~ln_cur[NLINES-1]};

    ppi_irq_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr_i  (soft_rst_i),
        .wr_i        (wr_irq),
        .wen_st_i    (reg_wdata_i[3:0]),
        .wen_lv_i    ({reg_wdata_i[7], reg_wdata_i[6], reg_wdata_i[4]}),
        .line_cur_i  (ln_cur[NSTICKY-1:0]),
        .line_prev_i (ln_prev[NSTICKY-1:0]),
        .lv_cond_i   (lv_cond),
        .lv_flag_o   (lv_flag),
        .st_en_o     (sticky_en_w),
        .st_pend_o   (sticky_pend_w),
        .st_evt_o    (sticky_evt_w)
    );

    // interrupt register read image and summary request
    always_comb begin
        irq_rd = {lv_flag[2], lv_flag[1], 1'b0, lv_flag[0], sticky_pend_w};
        ir_w   = |irq_rd;
    end

    ppi_irq_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr_i (soft_rst_i),
        .ctl_wr_i   (wr_ctl),
        .lvl_wr_i   (wr_lvl),
        .ie_wd_i    (reg_wdata_i[7]),
        .mode_wd_i  (reg_wdata_i[3:0]),
        .lvl_wd_i   (reg_wdata_i[5:4]),
        .pending_i  (ir_w),
        .ie_o       (ie_w),
        .il_o       (il_w),
        .mode_o     (mode_w),
        .irq_o      (irq_lvl_o)
    );

    // control and level read images
    always_comb begin
        ctl_rd = {ie_w, ir_w, il_w, mode_w};
        lvl_rd = {2'b00, il_w, 4'b0000};
    end

    // read data multiplexer
    always_comb begin
        case (reg_addr_i)
            A_CTRL:  reg_rdata_o = ctl_rd;
            A_IRQ:   reg_rdata_o = irq_rd;
            A_LVL:   reg_rdata_o = lvl_rd;
            default: reg_rdata_o = '0;
        endcase
    end

    assign mode_iom_o = mode_w[3];
    assign mode_dir_o = mode_w[2];
    assign dma_en_o   = mode_w[1:0];
endmodule

// File: rtl/ppi_irq_chk.sv
// Property checker for ppi_irq_ctrl, attached with bind below.
// Assumes the signals named at the bind are the bank and CSR outputs.
module ppi_irq_chk
    import ppi_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                soft_rst_i,
    input logic                reg_wr_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [NLVL_OUT-1:0] irq_lvl_o,
    input logic [NSTICKY-1:0]  sticky_en_w,
    input logic [NSTICKY-1:0]  sticky_pend_w,
    input logic [NSTICKY-1:0]  sticky_evt_w,
    input logic                ie_w,
    input logic                ir_w,
    input logic [LVLW-1:0]     il_w
);
    // R9
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lvl_o));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lvl_o) |-> $past(ie_w && ir_w));

    // R5
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_pend_w & ~$past(sticky_pend_w) & ~$past(sticky_evt_w & sticky_en_w)) == '0);

    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(soft_rst_i) |-> (($past(sticky_evt_w & sticky_en_w) & ~sticky_pend_w) == '0));

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst_i) |-> (sticky_en_w == '0 && sticky_pend_w == '0 && !ie_w && irq_lvl_o == '0));

    // R7
    level_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(il_w) |-> $past(reg_wr_i && reg_addr_i == A_LVL));
endmodule

bind ppi_irq_ctrl ppi_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst_i    (soft_rst_i),
    .reg_wr_i      (reg_wr_i),
    .reg_addr_i    (reg_addr_i),
    .irq_lvl_o     (irq_lvl_o),
    .sticky_en_w   (sticky_en_w),
    .sticky_pend_w (sticky_pend_w),
    .sticky_evt_w  (sticky_evt_w),
    .ie_w          (ie_w),
    .ir_w          (ir_w),
    .il_w          (il_w)
);

// File: tb/ppi_irq_ctrl_bench.sv
// Self-checking bench: a level/enable vector table walked by one loop,
// then directed tests for the sources, the clear rules and the resets.
module ppi_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       nack = 1'b1, nerror = 1'b1, sel = 1'b0, pe = 1'b0, busy = 1'b1;
    logic       ffull = 1'b0, fempty = 1'b1;
    logic [3:0] irq;
    logic       iom, dir;
    logic [1:0] dma;
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] r;

    always #2.5 clk = ~clk;

    ppi_irq_ctrl u_ppi_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .line_nack_i(nack), .line_nerror_i(nerror), .line_select_i(sel),
        .line_pe_i(pe), .line_busy_i(busy),
        .fifo_full_i(ffull), .fifo_empty_i(fempty),
        .irq_lvl_o(irq), .mode_iom_o(iom), .mode_dir_o(dir), .dma_en_o(dma)
    );

    // entries: {ie, level code[1:0], expected one-hot[3:0]}
    localparam logic [6:0] LVL_TBL [6] = '{
        {1'b1, 2'd0, 4'b0001}, {1'b1, 2'd1, 4'b0010}, {1'b1, 2'd2, 4'b0100},
        {1'b1, 2'd3, 4'b1000}, {1'b0, 2'd2, 4'b0000}, {1'b0, 2'd0, 4'b0000}};

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic settle;
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();
        // reset state
        rreg(2'd1, r); chk("R1 irq reg after reset", r, 8'h00);
        rreg(2'd0, r); chk("R7 ctrl after reset", r, 8'h00);
        chk("R9 output after reset", {4'h0, irq}, 8'h00);
        wreg(2'd3, 8'hFF); rreg(2'd3, r); chk("R1 unused address", r, 8'h00);
        wreg(2'd1, 8'h20); rreg(2'd1, r); chk("R1 bit5 reads zero", r, 8'h00);

        // level sources
        wreg(2'd1, 8'hD0);
        rreg(2'd1, r); chk("R2 empty follows", r, 8'h40);
        @(negedge clk) begin ffull = 1'b1; fempty = 1'b0; end
        rreg(2'd1, r); chk("R2 full follows", r, 8'h80);
        @(negedge clk) busy = 1'b0;
        repeat (2) @(posedge clk);
        rreg(2'd1, r); chk("R11 busy low after two edges", r, 8'h90);
        wreg(2'd1, 8'h00); rreg(2'd1, r); chk("R2 disabled reads zero", r, 8'h00);
        @(negedge clk) busy = 1'b1;
        settle();

        // level selection table (pending via FIFO full)
        wreg(2'd1, 8'h80);
        for (int i = 0; i < 6; i++) begin
            wreg(2'd2, {2'b00, LVL_TBL[i][5:4], 4'b0000});
            wreg(2'd0, {LVL_TBL[i][6], 7'b0});
            @(posedge clk); #1;
            chk("R9 level output", {4'h0, irq}, {4'h0, LVL_TBL[i][3:0]});
        end
        rreg(2'd0, r); chk("R8 IR set while IE clear", r, 8'h40);
        wreg(2'd1, 8'h00); rreg(2'd0, r); chk("R8 IR clear with nothing pending", r, 8'h00);

        // acknowledge: falling edge only, with latency
        wreg(2'd1, 8'h08);
        @(negedge clk) nack = 1'b0;
        repeat (2) @(posedge clk);
        rreg(2'd1, r); chk("R11 not yet after two edges", r, 8'h00);
        rreg(2'd1, r); chk("R11 ack after three edges", r, 8'h08);
        wreg(2'd1, 8'h08); rreg(2'd1, r); chk("R5 write one keeps", r, 8'h08);
        wreg(2'd1, 8'h00); rreg(2'd1, r); chk("R5 write zero clears", r, 8'h00);
        wreg(2'd1, 8'h08);
        @(negedge clk) nack = 1'b1;
        settle();
        rreg(2'd1, r); chk("R3 rising ack ignored", r, 8'h00);
        wreg(2'd1, 8'h00);
        @(negedge clk) nack = 1'b0;
        settle();
        rreg(2'd1, r); chk("R5 disabled bit not set", r, 8'h00);
        @(negedge clk) nack = 1'b1;
        settle();

        // either-edge sources
        wreg(2'd1, 8'h07);
        @(negedge clk) sel = 1'b1; settle();
        rreg(2'd1, r); chk("R4 select rise", r, 8'h02);
        @(negedge clk) pe = 1'b1; settle();
        rreg(2'd1, r); chk("R4 pe rise", r, 8'h03);
        @(negedge clk) nerror = 1'b0; settle();
        rreg(2'd1, r); chk("R4 error fall", r, 8'h07);
        wreg(2'd1, 8'h06); rreg(2'd1, r); chk("R5 clear only pe", r, 8'h06);
        @(negedge clk) pe = 1'b0; settle();
        rreg(2'd1, r); chk("R5 disabled pe stays clear", r, 8'h06);
        wreg(2'd1, 8'h07);
        @(negedge clk) pe = 1'b1; settle();
        wreg(2'd1, 8'h06);
        @(negedge clk) pe = 1'b0; settle();
        rreg(2'd1, r); chk("R4 pe fall while disabled", r, 8'h06);
        wreg(2'd1, 8'h07);
        @(negedge clk) pe = 1'b1; settle();
        wreg(2'd1, 8'h06);
        wreg(2'd1, 8'h07);
        @(negedge clk) pe = 1'b0; settle();
        rreg(2'd1, r); chk("R4 pe falling edge sets", r, 8'h07);
        wreg(2'd1, 8'h00); rreg(2'd1, r); chk("R5 clear all", r, 8'h00);

        // event in the same cycle as a clear-write
        wreg(2'd1, 8'h01);
        @(negedge clk) pe = 1'b1; settle();
        rreg(2'd1, r); chk("R6 setup pending", r, 8'h01);
        @(negedge clk) pe = 1'b0;
        repeat (2) @(posedge clk);
        wreg(2'd1, 8'h00);
        rreg(2'd1, r); chk("R6 event beats clear", r, 8'h01);
        wreg(2'd1, 8'h00); rreg(2'd1, r); chk("R6 later clear", r, 8'h00);

        // soft reset
        wreg(2'd2, 8'h20);
        wreg(2'd0, 8'hFF);
        wreg(2'd1, 8'h80);
        rreg(2'd0, r); chk("R7 ctrl layout", r, 8'hEF);
        chk("R7 mode outputs", {4'h0, iom, dir, dma}, 8'h0F);
        @(posedge clk); #1;
        chk("R9 level 5 output", {4'h0, irq}, 8'h04);
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        rreg(2'd0, r); chk("R10 soft reset keeps level", r, 8'h20);
        rreg(2'd1, r); chk("R10 soft reset clears irq reg", r, 8'h00);
        chk("R10 soft reset clears output", {4'h0, irq}, 8'h00);
        wreg(2'd0, 8'h40); rreg(2'd0, r); chk("R7 IR not writable", r, 8'h20);

        // hard reset clears level code
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rreg(2'd2, r); chk("R10 hard reset clears level", r, 8'h00);

        finish_run();
    end
endmodule